// File: doc/BRIEF.md
# Serial Port Baud Clock Generator

This block produces the timing references for one serial communication port. A fixed divide-by-2 stage runs ahead of a 12-bit programmable prescaler. Together they set the rate of an internal clock that is never faster than a quarter of the system clock. From that clock the block derives two outputs: a 16x oversampling enable for an asynchronous receiver, and a 1x bit enable for the shift logic. Both are single-cycle pulses in the system clock domain.

The block also produces the level for the external serial clock pin, and an enable that decides whether the pin is driven. In asynchronous mode the pin runs without stopping. A select bit chooses whether the pin carries the 1x baud clock or the raw 16x clock. In synchronous mode the select bit has no effect. The pin then carries the internal clock divided by 2, and transmitter and receiver share this bit clock. The pin toggles only while the transfer-active input is high, and it rests low when that input is low.

The divide field and the select bit are loaded through a write strobe. Hardware reset and a software reset both clear them. A new divide value is picked up only at the prescaler's next terminal count, so no period is ever cut short.

Top module: `baud_clk_gen`

## Requirements
- R1: The interval between `tick16` pulses is 4*(D+1) system cycles, where D is the stored 12-bit divide field. D=0 gives 4 cycles and D=4095 gives 16384 cycles.
- R2: Hardware reset (`rstN` low) and `softRst` both clear the divide field and the clock-out select bit. During reset, `tick16`, `tick1`, `sclkOut` and `sclkOe` are all 0.
- R3: In asynchronous mode (`syncMode`=0), `tick1` pulses once every 16 `tick16` pulses, which is every 64*(D+1) cycles. Every `tick1` pulse falls in the same cycle as a `tick16` pulse.
- R4: In asynchronous mode with the select bit set to 1, `sclkOut` toggles every 2*(D+1) cycles. The pin carries the 16x clock.
- R5: In asynchronous mode with the select bit at 0, `sclkOut` toggles every 32*(D+1) cycles. The pin carries the 1x clock.
- R6: In synchronous mode (`syncMode`=1) with `xferActive`=1, `sclkOut` toggles every 4*(D+1) cycles and `tick1` pulses every 8*(D+1) cycles, whatever the select bit holds. The fastest bit clock is therefore 8 system cycles.
- R7: In synchronous mode with `xferActive`=0, `sclkOut` is 0 from the next cycle on and `tick1` stays 0.
- R8: One cycle after `txClkDir` or `rxClkDir` is 1, `sclkOe` is 0. One cycle after both are 0, `sclkOe` is 1.
- R9: A write to the divide field takes effect at the prescaler's next terminal count. Suppose the field changes from Da to Db just after a `tick16` pulse. The next `tick16` interval is then 2*(Da+1)+2*(Db+1) cycles, and every interval after it is 4*(Db+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| softRst | input | 1 | Synchronous software reset; clears the configuration and the counters |
| cfgWrEn | input | 1 | Write strobe for the divide field and the select bit |
| cfgDivIn | input | 12 | Prescale divide field; the ratio is the value plus one |
| cfgCodIn | input | 1 | Clock-out select: 1 sends the 16x clock to the pin in asynchronous mode, 0 sends the 1x clock |
| syncMode | input | 1 | 1 selects synchronous mode, 0 selects asynchronous mode |
| txClkDir | input | 1 | Transmit clock direction: 1 means the clock comes from outside |
| rxClkDir | input | 1 | Receive clock direction: 1 means the clock comes from outside |
| xferActive | input | 1 | Gate from the transmitter or receiver: a transfer is in progress |
| tick16 | output | 1 | One-cycle pulse at the 16x oversampling rate |
| tick1 | output | 1 | One-cycle pulse at the bit rate |
| sclkOut | output | 1 | Registered level for the serial clock pin |
| sclkOe | output | 1 | Output enable for the serial clock pin |

## Verification
The assertions assume three things about the inputs. Reset and software reset arrive as clean synchronous levels. Mode, direction and gate inputs change only between clock edges. A software reset may hit the prescaler in any state. The stimulus stays inside these limits: it drives every input shortly after a falling edge, and it changes the mode, the select bit or the divide field only before discarding a few events, so that only settled periods are measured. The random part draws divide values from 0 to 15, and the largest divide value is then tried once in a directed case.

// File: rtl/baud_clk_pkg.sv
package baud_clk_pkg;
  typedef struct packed {
    logic clrCnt;   // software reset: restart prescaler and phase
    logic syncSel;  // synchronous mode
    logic codSel;   // async pin carries raw oversampling clock
    logic gateOn;   // transfer active, enables synchronous clock
  } baudCtl_t;
endpackage

// File: rtl/baud_clk_ctrl.sv
module baud_clk_ctrl
  import baud_clk_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic             cfgWrEn,
  input  logic [DIV_W-1:0] cfgDivIn,
  input  logic             cfgCodIn,
  input  logic             syncMode,
  input  logic             txClkDir,
  input  logic             rxClkDir,
  input  logic             xferActive,
  output logic [DIV_W-1:0] divVal,
  output baudCtl_t         ctl,
  output logic             sclkOe
);
  logic [DIV_W-1:0] divReg;
  logic             codReg;
  logic             extClk;

  assign extClk = txClkDir || rxClkDir;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= '0;
      codReg <= 1'b0;
      sclkOe <= 1'b0;
    end else begin
      sclkOe <= !extClk;
      if (softRst) begin
        divReg <= '0;
        codReg <= 1'b0;
      end else if (cfgWrEn) begin
        divReg <= cfgDivIn;
        codReg <= cfgCodIn;
      end
    end
  end

  always_comb begin
    ctl.clrCnt  = softRst;
    ctl.syncSel = syncMode;
    ctl.codSel  = codReg;
    ctl.gateOn  = xferActive;
  end

  assign divVal = divReg;

  assert_soft_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (divReg == '0) && !codReg);

  assert_oe_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    extClk |=> !sclkOe);

  assert_oe_on_R8: assert property (@(posedge clk) disable iff (!rstN)
    !extClk |=> sclkOe);
endmodule

// File: rtl/baud_clk_dp.sv
module baud_clk_dp
  import baud_clk_pkg::*;
#(
  parameter int DIV_W      = 12,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divVal,
  input  baudCtl_t         ctl,
  output logic             tick16,
  output logic             tick1,
  output logic             sclkOut
);
  localparam int PH_W = $clog2(OVERSAMPLE) + 1;  // half-periods per bit

  logic             pre2;
  logic [DIV_W-1:0] cnt;
  logic [PH_W-1:0]  phase;
  logic [PH_W-1:0]  phaseNext;
  logic             halfTick;
  logic             rise;

  assign halfTick  = pre2 && (cnt == '0);
  assign rise      = halfTick && !phase[0];
  assign phaseNext = phase + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre2    <= 1'b0;
      cnt     <= '0;
      phase   <= '0;
      tick16  <= 1'b0;
      tick1   <= 1'b0;
      sclkOut <= 1'b0;
    end else if (ctl.clrCnt) begin
      pre2    <= 1'b0;
      cnt     <= '0;
      phase   <= '0;
      tick16  <= 1'b0;
      tick1   <= 1'b0;
      sclkOut <= 1'b0;
    end else begin
      pre2 <= !pre2;
      if (pre2) begin
        if (cnt == '0) cnt <= divVal;  // new ratio only at terminal count
        else           cnt <= cnt - 1'b1;
      end
      if (halfTick) phase <= phaseNext;
      tick16 <= rise;
      if (ctl.syncSel) begin
        tick1 <= rise && ctl.gateOn && sclkOut;
        if (!ctl.gateOn)  sclkOut <= 1'b0;
        else if (rise)    sclkOut <= !sclkOut;
      end else begin
        tick1 <= rise && (phase == '0);
        if (halfTick)
          sclkOut <= ctl.codSel ? phaseNext[0] : phaseNext[PH_W-1];
      end
    end
  end

  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pre2 && cnt != '0 && !ctl.clrCnt) |=> cnt == $past(cnt) - 1'b1);

  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rstN)
    tick16 |=> !tick16);

  assert_bit_on_sample_R3: assert property (@(posedge clk) disable iff (!rstN)
    tick1 |-> tick16);

  assert_sync_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.syncSel && !ctl.gateOn) |=> !sclkOut && !tick1);
endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen
  import baud_clk_pkg::*;
#(
  parameter int DIV_W      = 12,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic             cfgWrEn,
  input  logic [DIV_W-1:0] cfgDivIn,
  input  logic             cfgCodIn,
  input  logic             syncMode,
  input  logic             txClkDir,
  input  logic             rxClkDir,
  input  logic             xferActive,
  output logic             tick16,
  output logic             tick1,
  output logic             sclkOut,
  output logic             sclkOe
);
  baudCtl_t         ctl;
  logic [DIV_W-1:0] divVal;

  baud_clk_ctrl #(.DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .cfgWrEn(cfgWrEn),
    .cfgDivIn(cfgDivIn), .cfgCodIn(cfgCodIn), .syncMode(syncMode),
    .txClkDir(txClkDir), .rxClkDir(rxClkDir), .xferActive(xferActive),
    .divVal(divVal), .ctl(ctl), .sclkOe(sclkOe)
  );

  baud_clk_dp #(.DIV_W(DIV_W), .OVERSAMPLE(OVERSAMPLE)) dp_i (
    .clk(clk), .rstN(rstN), .divVal(divVal), .ctl(ctl),
    .tick16(tick16), .tick1(tick1), .sclkOut(sclkOut)
  );
endmodule

// File: tb/baud_clk_gen_tb_top.sv
module baud_clk_gen_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softRst = 1'b0, cfgWrEn = 1'b0, cfgCodIn = 1'b0;
  logic [11:0] cfgDivIn = '0;
  logic syncMode = 1'b0, txClkDir = 1'b0, rxClkDir = 1'b0, xferActive = 1'b0;
  logic tick16, tick1, sclkOut, sclkOe;
  int errors = 0, checks = 0;
  longint cyc = 0;

  always #2.5 clk = ~clk;  // 200 MHz
  always @(posedge clk) cyc <= cyc + 1;

  baud_clk_gen dut_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .cfgWrEn(cfgWrEn),
    .cfgDivIn(cfgDivIn), .cfgCodIn(cfgCodIn), .syncMode(syncMode),
    .txClkDir(txClkDir), .rxClkDir(rxClkDir), .xferActive(xferActive),
    .tick16(tick16), .tick1(tick1), .sclkOut(sclkOut), .sclkOe(sclkOe)
  );

  function automatic int expTick16(int d); return 4 * (d + 1); endfunction
  function automatic int expTick1(bit s, int d); return s ? 8 * (d + 1) : 64 * (d + 1); endfunction
  function automatic int expPinHalf(bit s, bit c, int d);
    if (s) return 4 * (d + 1);
    return c ? 2 * (d + 1) : 32 * (d + 1);
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sel: 0 tick16, 1 tick1, 2 pin toggle; returns cycles between two events
  task automatic waitEvt(int sel, output longint t);
    logic prevPin = sclkOut;
    int guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (guard > 40000) begin t = -1; return; end
      if ((sel == 0 && tick16) || (sel == 1 && tick1) ||
          (sel == 2 && sclkOut != prevPin)) begin t = cyc; return; end
      prevPin = sclkOut;
    end
  endtask

  task automatic measure(int sel, int skip, output longint iv);
    longint a, b;
    for (int i = 0; i < skip; i++) waitEvt(sel, a);
    waitEvt(sel, a);
    waitEvt(sel, b);
    iv = (a < 0 || b < 0) ? -1 : b - a;
  endtask

  task automatic writeCfg(int d, bit c);
    @(negedge clk);
    cfgDivIn = 12'(d); cfgCodIn = c; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  initial begin
    #(5ns * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint iv;
    int d;
    bit c, s;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    // R2 reset state
    check("R2 tick16 in reset", tick16, 0);
    check("R2 tick1 in reset", tick1, 0);
    check("R2 sclkOut in reset", sclkOut, 0);
    check("R2 sclkOe in reset", sclkOe, 0);
    rstN = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R8 oe with both dirs clear", sclkOe, 1);
    measure(0, 1, iv); check("R1 tick16 after reset D=0", iv, 4);
    measure(2, 1, iv); check("R5 reset select clear pin", iv, 32);

    // random async/sync mix, gate held on
    xferActive = 1'b1;
    for (int k = 0; k < 10; k++) begin
      d = $urandom_range(0, 15);
      c = $urandom_range(0, 1);
      s = $urandom_range(0, 1);
      @(negedge clk); syncMode = s;
      writeCfg(d, c);
      measure(0, 3, iv); check("R1 tick16 random", iv, expTick16(d));
      measure(1, 2, iv); check(s ? "R6 sync bit tick" : "R3 async bit tick", iv, expTick1(s, d));
      measure(2, 2, iv);
      check(s ? "R6 sync pin, select ignored" : (c ? "R4 16x pin" : "R5 1x pin"), iv, expPinHalf(s, c, d));
    end

    // R6 fastest sync bit clock with select set
    @(negedge clk); syncMode = 1'b1;
    writeCfg(0, 1);
    measure(1, 2, iv); check("R6 fastest sync bit", iv, 8);

    // R7 gate off
    @(negedge clk); xferActive = 1'b0;
    begin
      int seen = 0;
      @(negedge clk);
      repeat (300) begin
        @(negedge clk);
        if (sclkOut || tick1) seen++;
      end
      check("R7 gated idle activity", seen, 0);
    end
    @(negedge clk); xferActive = 1'b1;
    measure(2, 1, iv); check("R6 sync restart pin", iv, 4);

    // R8 direction bits
    @(negedge clk); txClkDir = 1'b1;
    @(negedge clk); check("R8 oe off tx dir", sclkOe, 0);
    txClkDir = 1'b0; rxClkDir = 1'b1;
    @(negedge clk); check("R8 oe off rx dir", sclkOe, 0);
    rxClkDir = 1'b0;
    @(negedge clk); check("R8 oe back on", sclkOe, 1);

    // R9 divide change lands at terminal count
    @(negedge clk); syncMode = 1'b0;
    writeCfg(15, 1);
    measure(0, 3, iv); check("R9 old ratio", iv, 64);
    waitEvt(0, iv);
    cfgDivIn = 12'd0; cfgWrEn = 1'b1;
    @(negedge clk); cfgWrEn = 1'b0;
    begin
      longint tw, t2;
      tw = iv;
      waitEvt(0, t2);
      check("R9 transition interval", t2 - tw, 2 * 16 + 2 * 1);
    end
    measure(0, 0, iv); check("R9 new ratio", iv, 4);

    // R2 software reset clears field and select
    writeCfg(5, 1);
    measure(0, 2, iv); check("R1 D=5", iv, 24);
    @(negedge clk); softRst = 1'b1;
    @(negedge clk); softRst = 1'b0;
    measure(0, 1, iv); check("R2 soft reset clears divide", iv, 4);
    measure(2, 1, iv); check("R2 soft reset clears select", iv, 32);

    // R1 largest ratio
    writeCfg(4095, 1);
    measure(0, 1, iv); check("R1 D=4095", iv, 16384);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule